// File: doc/BRIEF.md
# I2C Target Address Recogniser

This block sits on the receive side of an I2C target interface, after the shift register that assembles bytes. It looks only at the first byte that arrives after a START or a repeated START. It decides whether that byte selects this device, either through the programmed 7-bit own address or through the general call address. It reports the result to the surrounding control logic. It also gives the acknowledge decision for the ninth clock, and the R/W direction the controller requested.

Recognising the general call address can be turned on or off. Whether a recognised address is acknowledged is set by its own enable, separate from recognition. The block keeps working while the rest of the system sleeps. A match made during sleep raises a wake request. If some other source wakes the system while such a match is pending, the block drops the transfer and goes back to idle.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, match_pulse, gen_call, rw_bit, ack_drive and wake_req are all 0.
- R2: A strobe with rx_valid=1 and rx_first=1 whose bits [7:1] equal own_addr gives match_pulse=1 in the cycle after the strobe. In that same cycle rw_bit equals bit 0 of the byte.
- R3: With gc_enable=1, an address byte of 8'h00 gives match_pulse=1 and gen_call=1 in the cycle after the strobe. With gc_enable=0 the same byte gives neither, provided own_addr is not zero.
- R4: The byte 8'h01 (general call address with R/W=1) never sets gen_call and never matches through the general call path.
- R5: A strobe with rx_first=0 never produces match_pulse, whatever the byte holds.
- R6: ack_drive is 1 (SDA pulled low on the ninth clock) from the cycle after a matching address strobe only when ack_enable was 1 at that strobe. A strobe that does not match leaves ack_drive at 0. Any later rx_valid strobe clears ack_drive in the following cycle.
- R7: match_pulse lasts one cycle for each matching strobe.
- R8: A match while sleep_mode=1 raises wake_req in the next cycle. wake_req stays high while sleep_mode stays 1, and falls in the cycle after sleep_mode goes to 0.
- R9: A cycle with other_wake=1 and sleep_mode=1, while the block is selected, clears ack_drive, gen_call, rw_bit and wake_req in the next cycle and returns the block to idle. other_wake with sleep_mode=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte | input | 8 | Byte received from the shift register |
| rx_valid | input | 1 | One-cycle strobe: rx_byte is complete |
| rx_first | input | 1 | The strobed byte is the first one after START or repeated START |
| own_addr | input | 7 | Programmed own address |
| gc_enable | input | 1 | Enables recognition of the general call address |
| ack_enable | input | 1 | Enables acknowledging a recognised address |
| sleep_mode | input | 1 | The rest of the system is in a low-power state |
| other_wake | input | 1 | Some other wake source has fired |
| match_pulse | output | 1 | One-cycle pulse on address recognition |
| gen_call | output | 1 | The current selection came from the general call address |
| rw_bit | output | 1 | R/W bit of the recognised address byte |
| ack_drive | output | 1 | 1 = pull SDA low on the ninth clock |
| wake_req | output | 1 | Wake request caused by a match during sleep |

## Verification
The assertions assume that rx_valid is a single-cycle strobe. They assume that own_addr, gc_enable and ack_enable are stable when a strobe arrives, and that rx_first is only meaningful together with rx_valid. The bench changes configuration inputs only between strobes, and raises each strobe for exactly one cycle. Address values are chosen so that the own-address path and the general call path can be told apart; own_addr is nonzero whenever the general call path is tested.

// File: rtl/i2c_addr_match_pkg.sv
package i2c_addr_match_pkg;
    localparam int unsigned ADDR_W = 7;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEL  = 1'b1
    } sel_state_e;

    typedef struct packed {
        sel_state_e st;
        logic       match;
        logic       gc;
        logic       rw;
        logic       ack;
        logic       wake;
    } match_regs_t;
endpackage

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic [ADDR_W:0]   addr_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_enable,
    output logic              own_hit,
    output logic              gc_hit
);
    localparam int unsigned BYTE_W = ADDR_W + 1;

    always_comb begin
        own_hit = (addr_byte[BYTE_W-1:1] == own_addr);
        // general call: all address bits zero and a write direction
        gc_hit  = gc_enable && (addr_byte == '0);
    end
endmodule

// File: rtl/i2c_match_ctrl.sv
module i2c_match_ctrl
    import i2c_addr_match_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic first,
    input  logic own_hit,
    input  logic gc_hit,
    input  logic rw_in,
    input  logic ack_enable,
    input  logic sleep_mode,
    input  logic other_wake,
    output logic match_pulse,
    output logic gen_call,
    output logic rw_bit,
    output logic ack_drive,
    output logic wake_req
);
    match_regs_t r_d, r_q;
    logic        hit_d;
    logic        abort_d;

    always_comb begin
        r_d         = r_q;
        r_d.match   = 1'b0;
        hit_d       = own_hit || gc_hit;
        abort_d     = other_wake && sleep_mode && (r_q.st == ST_SEL);
        if (strobe) begin
            r_d.ack = 1'b0;
        end
        if (strobe && first) begin
            if (hit_d) begin
                r_d.st    = ST_SEL;
                r_d.match = 1'b1;
                r_d.gc    = gc_hit;
                r_d.rw    = rw_in;
                r_d.ack   = ack_enable;
                r_d.wake  = sleep_mode;
            end else begin
                r_d.st   = ST_IDLE;
                r_d.gc   = 1'b0;
                r_d.rw   = 1'b0;
                r_d.wake = 1'b0;
            end
        end
        if (!sleep_mode) begin
            r_d.wake = 1'b0;
        end
        if (abort_d) begin
            r_d = '{st: ST_IDLE, match: 1'b0, gc: 1'b0, rw: 1'b0, ack: 1'b0, wake: 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, match: 1'b0, gc: 1'b0, rw: 1'b0, ack: 1'b0, wake: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign match_pulse = r_q.match;
    assign gen_call    = r_q.gc;
    assign rw_bit      = r_q.rw;
    assign ack_drive   = r_q.ack;
    assign wake_req    = r_q.wake;

    // R5: a match needs a first-byte strobe one cycle earlier
    a_r5_match_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(strobe && first));

    // R6: acknowledge only starts when it was enabled at the strobe
    a_r6_ack_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_drive) |-> $past(ack_enable && strobe && first));

    // R3: general call is only reported while selected
    a_r3_gc_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        gen_call |-> (r_q.st == ST_SEL));

    // R8: a wake request only follows a sleeping cycle
    a_r8_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(sleep_mode));

    // R9: another wake source during a sleeping selection drops the transfer
    a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (other_wake && sleep_mode && r_q.st == ST_SEL) |=> (!ack_drive && !wake_req && !gen_call && r_q.st == ST_IDLE));

    // R6: any new byte ends the acknowledge
    a_r6_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !first) |=> !ack_drive);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_addr_match_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW:0]   rx_byte,
    input  logic          rx_valid,
    input  logic          rx_first,
    input  logic [AW-1:0] own_addr,
    input  logic          gc_enable,
    input  logic          ack_enable,
    input  logic          sleep_mode,
    input  logic          other_wake,
    output logic          match_pulse,
    output logic          gen_call,
    output logic          rw_bit,
    output logic          ack_drive,
    output logic          wake_req
);
    logic own_hit_c;
    logic gc_hit_c;

    i2c_addr_cmp #(.ADDR_W(AW)) u_cmp (
        .addr_byte (rx_byte),
        .own_addr  (own_addr),
        .gc_enable (gc_enable),
        .own_hit   (own_hit_c),
        .gc_hit    (gc_hit_c)
    );

    i2c_match_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (rx_valid),
        .first       (rx_first),
        .own_hit     (own_hit_c),
        .gc_hit      (gc_hit_c),
        .rw_in       (rx_byte[0]),
        .ack_enable  (ack_enable),
        .sleep_mode  (sleep_mode),
        .other_wake  (other_wake),
        .match_pulse (match_pulse),
        .gen_call    (gen_call),
        .rw_bit      (rw_bit),
        .ack_drive   (ack_drive),
        .wake_req    (wake_req)
    );
endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0;
    logic       rx_first = 1'b0;
    logic [6:0] own_addr = 7'h5A;
    logic       gc_enable = 1'b0;
    logic       ack_enable = 1'b1;
    logic       sleep_mode = 1'b0;
    logic       other_wake = 1'b0;
    logic       match_pulse, gen_call, rw_bit, ack_drive, wake_req;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    i2c_addr_match dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_first(rx_first), .own_addr(own_addr), .gc_enable(gc_enable),
        .ack_enable(ack_enable), .sleep_mode(sleep_mode), .other_wake(other_wake),
        .match_pulse(match_pulse), .gen_call(gen_call), .rw_bit(rw_bit),
        .ack_drive(ack_drive), .wake_req(wake_req)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // drive a one-cycle strobe at a falling edge; result is sampled at the next falling edge
    task automatic send(input logic [7:0] b, input logic first);
        @(negedge clk);
        rx_byte  = b;
        rx_first = first;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_first = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "match_pulse", match_pulse, 1'b0);
        check("R1", "gen_call", gen_call, 1'b0);
        check("R1", "rw_bit", rw_bit, 1'b0);
        check("R1", "ack_drive", ack_drive, 1'b0);
        check("R1", "wake_req", wake_req, 1'b0);
    endtask

    task automatic t_own();
        send({7'h5A, 1'b1}, 1'b1);
        check("R2", "match on own read", match_pulse, 1'b1);
        check("R2", "rw read", rw_bit, 1'b1);
        check("R6", "ack on own", ack_drive, 1'b1);
        check("R3", "no gc on own", gen_call, 1'b0);
        @(negedge clk);
        check("R7", "pulse one cycle", match_pulse, 1'b0);
        check("R6", "ack held", ack_drive, 1'b1);
        send({7'h5A, 1'b0}, 1'b0);
        check("R5", "data byte no match", match_pulse, 1'b0);
        check("R6", "ack cleared by data", ack_drive, 1'b0);
        send({7'h5A, 1'b0}, 1'b1);
        check("R2", "match on own write", match_pulse, 1'b1);
        check("R2", "rw write", rw_bit, 1'b0);
        send({7'h5B, 1'b0}, 1'b1);
        check("R2", "miss no match", match_pulse, 1'b0);
        check("R6", "miss no ack", ack_drive, 1'b0);
    endtask

    task automatic t_gc();
        gc_enable = 1'b1;
        send(8'h00, 1'b1);
        check("R3", "gc match", match_pulse, 1'b1);
        check("R3", "gc flag", gen_call, 1'b1);
        check("R6", "gc ack", ack_drive, 1'b1);
        send(8'h01, 1'b1);
        check("R4", "gc read no match", match_pulse, 1'b0);
        check("R4", "gc read no flag", gen_call, 1'b0);
        gc_enable = 1'b0;
        send(8'h00, 1'b1);
        check("R3", "gc disabled no match", match_pulse, 1'b0);
        check("R3", "gc disabled no flag", gen_call, 1'b0);
    endtask

    task automatic t_noack();
        ack_enable = 1'b0;
        send({7'h5A, 1'b0}, 1'b1);
        check("R6", "match without ack", match_pulse, 1'b1);
        check("R6", "ack disabled", ack_drive, 1'b0);
        ack_enable = 1'b1;
    endtask

    task automatic t_wake();
        sleep_mode = 1'b1;
        send({7'h5A, 1'b0}, 1'b1);
        check("R8", "wake raised", wake_req, 1'b1);
        @(negedge clk);
        check("R8", "wake held", wake_req, 1'b1);
        sleep_mode = 1'b0;
        @(negedge clk);
        check("R8", "wake dropped", wake_req, 1'b0);
        check("R9", "awake keeps ack", ack_drive, 1'b1);
    endtask

    task automatic t_abort();
        other_wake = 1'b1;
        @(negedge clk);
        other_wake = 1'b0;
        check("R9", "awake other_wake ignored", ack_drive, 1'b1);
        sleep_mode = 1'b1;
        gc_enable  = 1'b1;
        send(8'h00, 1'b1);
        check("R9", "gc selected before abort", gen_call, 1'b1);
        other_wake = 1'b1;
        @(negedge clk);
        other_wake = 1'b0;
        check("R9", "abort ack", ack_drive, 1'b0);
        check("R9", "abort wake", wake_req, 1'b0);
        check("R9", "abort gc", gen_call, 1'b0);
        sleep_mode = 1'b0;
        gc_enable  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_own();
        t_gc();
        t_noack();
        t_wake();
        t_abort();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule